// File: doc/BRIEF.md
# SPI EEPROM Configuration Boot Loader

This block is an SPI master that fetches a device configuration image from an external 2048-byte serial EEPROM each time the chip leaves reset. It starts only when the mode straps select serial-memory boot. It then lowers chip select and sends a single read command for address zero. After that it clocks in the whole image as one continuous burst.

Each byte that arrives goes out on a simple record stream. The stream carries the byte, its EEPROM address and a one-cycle strobe. Register-write logic elsewhere in the chip consumes it. When the final byte has been taken, chip select is released and a completion flag rises. The flag stays high until the next reset. A variant input selects one of two image lengths: one for the single-port device and one for the quad-port device. A clock-phase input chooses which SCK edge changes MOSI and which edge samples MISO.

Top module: `cfg_boot_loader`

## Requirements
- R1: A load runs only when the straps read hardware-mode = 0, mode1 = 1 and mode0 = 0. With any other strap value, chip select stays high, SCK stays low and the done flag stays low.
- R2: When the straps are enabled, chip select falls on the first clock edge after reset is released. This holds after power-up and after every later reset.
- R3: The first 8 bits shifted out on MOSI, MSB first, are the read opcode 0x03.
- R4: The opcode is followed by 16 zero address bits. After those, every SCK period carries one data bit from MISO, MSB first. Byte k of the image has address k.
- R5: Chip select stays low without a break from the start of the opcode until the end of the SCK period of the last image bit. It goes high at that edge.
- R6: SCK is the system clock divided by CLK_DIV (default 12). It idles low and rises CLK_DIV/2 clocks into each bit period. It is low whenever chip select is high.
- R7: With clk_phase = 0, MOSI changes only on falling SCK edges, with the first bit present before the first rising edge, and MISO is sampled on rising edges. With clk_phase = 1, MOSI changes on rising edges and MISO is sampled on falling edges.
- R8: With quad_sel = 0 the image is 412 bytes (addresses 0x000 to 0x19B). With quad_sel = 1 it is 1029 bytes (0x000 to 0x404).
- R9: Each byte is presented with rec_valid high for exactly one cycle, in the cycle after the sampling edge of its last bit. rec_addr and rec_data are valid alongside it.
- R10: load_done rises on the same edge that releases chip select. It then stays high until the next reset.
- R11: A reset asserted in the middle of a load immediately returns chip select high, SCK low and done low. Releasing reset starts a fresh load from the opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts a load |
| strap_hwmode | input | 1 | Hardware-mode strap, must be 0 to boot from EEPROM |
| strap_mode1 | input | 1 | Mode strap bit 1, must be 1 |
| strap_mode0 | input | 1 | Mode strap bit 0, must be 0 |
| clk_phase | input | 1 | SCK edge selection for MOSI launch and MISO sampling |
| quad_sel | input | 1 | Image length variant: 0 single-port, 1 quad-port |
| spi_cs_n | output | 1 | EEPROM chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |
| rec_valid | output | 1 | One-cycle strobe for a received byte |
| rec_addr | output | ADDR_W | EEPROM address of the byte |
| rec_data | output | 8 | Received byte |
| load_done | output | 1 | Image fully received; held until reset |

## Verification
A bit counter that is off by one in either direction first shows up on the record stream. A byte then appears with the wrong address or with its bits rotated, at the latest eight SCK periods after the error. An early or late end shows as chip select and load_done changing a whole bit period away from the expected edge. Divider or phase errors change SCK or MOSI in the very next system clock, and a reference comparison on every clock catches them there. A wrong header bit is caught by the EEPROM model once the 24th SCK edge has completed the command.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

   typedef enum logic [1:0] {
      LD_IDLE = 2'd0,
      LD_XFER = 2'd1,
      LD_DONE = 2'd2
   } ld_state_t;

   localparam logic [7:0]  RD_OPCODE = 8'h03;
   localparam logic [15:0] RD_START  = 16'h0000;
   localparam int          HDR_BITS  = 24;

endpackage

// File: rtl/cfgl_sck_gen.sv
module cfgl_sck_gen #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic rise_evt,
   output logic fall_evt
);
   localparam int HALF = DIV / 2;
   localparam int PW   = $clog2(DIV);

   logic [PW-1:0] ph;

   assign rise_evt = run && (ph == PW'(HALF - 1));
   assign fall_evt = run && (ph == PW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= '0;
         sck <= 1'b0;
      end else if (!run) begin
         ph  <= '0;
         sck <= 1'b0;
      end else begin
         ph <= fall_evt ? '0 : ph + 1'b1;
         if (rise_evt)      sck <= 1'b1;
         else if (fall_evt) sck <= 1'b0;
      end
   end

   // R6: SCK low when no transfer runs, rises mid period, falls at wrap
   a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !sck);
   a_r6_rise_mid: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> (ph == PW'(HALF)));
   a_r6_fall_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck) |-> (ph == '0));

endmodule

// File: rtl/cfgl_tx.sv
module cfgl_tx #(
   parameter int BIT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cpha,
   input  logic             rise_evt,
   input  logic             fall_evt,
   input  logic [BIT_W-1:0] bitcnt,
   output logic             mosi
);
   import cfgl_pkg::*;

   localparam logic [HDR_BITS-1:0] HDR = {RD_OPCODE, RD_START};

   function automatic logic hdr_bit(input logic [BIT_W-1:0] idx);
      logic [4:0] pos;
      if (idx >= BIT_W'(HDR_BITS)) return 1'b0;
      pos = 5'(HDR_BITS - 1) - idx[4:0];
      return HDR[pos];
   endfunction

   logic             launch;
   logic [BIT_W-1:0] next_idx;

   assign launch   = cpha ? rise_evt : fall_evt;
   assign next_idx = cpha ? bitcnt : bitcnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mosi <= 1'b0;
      else if (start)  mosi <= cpha ? 1'b0 : hdr_bit('0);
      else if (launch) mosi <= hdr_bit(next_idx);
   end

   // R7: MOSI moves only on its launch edge
   a_r7_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(start || (cpha ? rise_evt : fall_evt)) |=> $stable(mosi));

endmodule

// File: rtl/cfgl_rx.sv
module cfgl_rx #(
   parameter int BIT_W  = 14,
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp,
   input  logic [BIT_W-1:0]  bitcnt,
   input  logic              miso,
   output logic              valid,
   output logic [ADDR_W-1:0] addr,
   output logic [7:0]        data
);
   import cfgl_pkg::*;

   logic [6:0]       sr;
   logic             byte_end;
   logic [BIT_W-1:0] data_bits;

   assign data_bits = bitcnt - BIT_W'(HDR_BITS);
   assign byte_end  = (bitcnt >= BIT_W'(HDR_BITS)) && (bitcnt[2:0] == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr    <= '0;
         valid <= 1'b0;
         addr  <= '0;
         data  <= '0;
      end else begin
         valid <= 1'b0;
         if (smp) begin
            sr <= {sr[5:0], miso};
            if (byte_end) begin
               valid <= 1'b1;
               data  <= {sr, miso};
               addr  <= ADDR_W'(data_bits >> 3);
            end
         end
      end
   end

   // R9: a record strobe never lasts two cycles
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader #(
   parameter int CLK_DIV      = 12,
   parameter int LEN_SINGLE   = 412,
   parameter int LEN_QUAD     = 1029,
   parameter int ADDR_W       = 11,
   parameter bit QUAD_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_hwmode,
   input  logic              strap_mode1,
   input  logic              strap_mode0,
   input  logic              clk_phase,
   input  logic              quad_sel,
   output logic              spi_cs_n,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              rec_valid,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [7:0]        rec_data,
   output logic              load_done
);
   import cfgl_pkg::*;

   localparam int MAX_LEN = (LEN_QUAD > LEN_SINGLE) ? LEN_QUAD : LEN_SINGLE;
   localparam int BIT_W   = $clog2(HDR_BITS + 8 * MAX_LEN + 1);

   generate
      if (CLK_DIV < 4 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 4");
      end
      if (MAX_LEN > (1 << ADDR_W) || LEN_SINGLE < 1) begin : g_bad_len
         $error("image lengths must fit the address width");
      end
   endgenerate

   logic [ADDR_W:0] img_len;

   generate
      if (QUAD_SUPPORT) begin : g_two_len
         assign img_len = quad_sel ? (ADDR_W+1)'(LEN_QUAD) : (ADDR_W+1)'(LEN_SINGLE);
      end else begin : g_one_len
         logic unused_quad;
         assign unused_quad = quad_sel;
         assign img_len     = (ADDR_W+1)'(LEN_SINGLE);
      end
   endgenerate

   ld_state_t        state;
   logic [BIT_W-1:0] bitcnt;
   logic [BIT_W-1:0] last_bit;
   logic             cpha_q;
   logic             enable, start, run;
   logic             rise_evt, fall_evt, smp;

   assign enable   = !strap_hwmode && strap_mode1 && !strap_mode0;
   assign start    = (state == LD_IDLE) && enable;
   assign run      = (state == LD_XFER);
   assign last_bit = BIT_W'(HDR_BITS) + BIT_W'({img_len, 3'b000}) - 1'b1;
   assign smp      = cpha_q ? fall_evt : rise_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= LD_IDLE;
         bitcnt    <= '0;
         spi_cs_n  <= 1'b1;
         load_done <= 1'b0;
         cpha_q    <= 1'b0;
      end else begin
         case (state)
            LD_IDLE: if (enable) begin
               state    <= LD_XFER;
               spi_cs_n <= 1'b0;
               bitcnt   <= '0;
               cpha_q   <= clk_phase;
            end
            LD_XFER: if (fall_evt) begin
               if (bitcnt == last_bit) begin
                  state     <= LD_DONE;
                  spi_cs_n  <= 1'b1;
                  load_done <= 1'b1;
               end else begin
                  bitcnt <= bitcnt + 1'b1;
               end
            end
            default: state <= LD_DONE;
         endcase
      end
   end

   cfgl_sck_gen #(.DIV(CLK_DIV)) i_sck (
      .clk(clk), .rst_n(rst_n), .run(run),
      .sck(spi_sck), .rise_evt(rise_evt), .fall_evt(fall_evt)
   );

   cfgl_tx #(.BIT_W(BIT_W)) i_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .cpha(cpha_q),
      .rise_evt(rise_evt), .fall_evt(fall_evt), .bitcnt(bitcnt), .mosi(spi_mosi)
   );

   cfgl_rx #(.BIT_W(BIT_W), .ADDR_W(ADDR_W)) i_rx (
      .clk(clk), .rst_n(rst_n), .smp(smp), .bitcnt(bitcnt), .miso(spi_miso),
      .valid(rec_valid), .addr(rec_addr), .data(rec_data)
   );

   // R1: with the straps off, chip select stays released
   a_r1_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LD_IDLE && !enable) |=> spi_cs_n);
   // R5: no gap in chip select while bits are still due
   a_r5_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> !spi_cs_n);
   // R10: done is sticky and comes with an idle bus
   a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> (spi_cs_n && !spi_sck));
   // R8: the last record before done carries the final image address
   a_r8_last_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_done) |-> (rec_addr == ADDR_W'(img_len - 1'b1)));

endmodule

// File: tb/test_cfg_boot_loader.sv
module test_cfg_boot_loader;

   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;
   localparam int LS   = 412;
   localparam int LQ   = 1029;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s_hw = 1'b0, s_m1 = 1'b1, s_m0 = 1'b0;
   logic cpha = 1'b0, quad = 1'b0;
   logic cs_n, sck, mosi, miso = 1'b0;
   logic vld, done;
   logic [10:0] addr;
   logic [7:0]  data;

   int n_cmp = 0, n_bad = 0;
   int e = -1;
   int nbytes = 0;
   int last_addr = -1;
   bit finished = 0;

   always #2 clk = ~clk;

   cfg_boot_loader #(.CLK_DIV(DIV), .LEN_SINGLE(LS), .LEN_QUAD(LQ)) i_cfg_boot_loader (
      .clk(clk), .rst_n(rst_n), .strap_hwmode(s_hw), .strap_mode1(s_m1),
      .strap_mode0(s_m0), .clk_phase(cpha), .quad_sel(quad),
      .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso),
      .rec_valid(vld), .rec_addr(addr), .rec_data(data), .load_done(done)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
      end
   endtask

   function automatic int mem_byte(input int k);
      return (k * 37 + (k >> 8) * 11 + 5) & 8'hFF;
   endfunction

   function automatic int hb(input int i);
      if (i < 24) return (24'h030000 >> (23 - i)) & 1;
      return 0;
   endfunction

   function automatic bit enabled();
      return !s_hw && s_m1 && !s_m0;
   endfunction

   // EEPROM slave model
   int   rx_cnt = 0;
   logic [23:0] cmd = '0;

   always @(negedge cs_n) begin
      rx_cnt = 0;
      cmd    = '0;
   end

   task automatic slave_sample();
      if (rx_cnt < 24) cmd = {cmd[22:0], mosi};
      rx_cnt++;
      if (rx_cnt == 24) chk("R3/R4", "read command", int'(cmd), 32'h030000);
   endtask

   task automatic slave_launch();
      if (rx_cnt >= 24) begin
         int k, b;
         k = (rx_cnt - 24) / 8;
         b = 7 - ((rx_cnt - 24) % 8);
         miso = mem_byte(k)[b];
      end
   endtask

   always @(posedge sck) if (!cs_n) begin
      if (!cpha) slave_sample(); else slave_launch();
   end
   always @(negedge sck) if (!cs_n) begin
      if (!cpha) slave_launch(); else slave_sample();
   end

   // reference timeline: e counts edges since the transfer-entry edge
   always @(posedge clk) begin
      if (!rst_n) e = -1;
      else if (e >= 0 || enabled()) e = e + 1;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         nbytes = 0;
         last_addr = -1;
         chk("R11", "cs_n in reset", cs_n, 1);
         chk("R11", "sck in reset", sck, 0);
         chk("R11", "done in reset", done, 0);
         chk("R11", "valid in reset", vld, 0);
      end else begin
         int tbits, b, p, s, xcs, xsck, xmosi, xdone, xvld, kb;
         tbits = 24 + 8 * (quad ? LQ : LS);
         xcs = 1; xsck = 0; xmosi = 0; xdone = 0; xvld = 0; kb = 0;
         if (e >= 0 && e < tbits * DIV) begin
            b = e / DIV;
            p = e % DIV;
            xcs  = 0;
            xsck = (p >= HALF);
            if (!cpha) xmosi = hb(b);
            else xmosi = (p >= HALF) ? hb(b) : ((b == 0) ? 0 : hb(b - 1));
         end
         if (e >= tbits * DIV) xdone = 1;
         s = cpha ? e - DIV : e - HALF;
         if (e >= 0 && s >= 0 && (s % DIV) == 0) begin
            b = s / DIV;
            if (b >= 24 && b < tbits && (b % 8) == 7) begin
               xvld = 1;
               kb = (b - 24) / 8;
            end
         end
         chk("R2/R5", "cs_n", cs_n, xcs);
         chk("R6", "sck", sck, xsck);
         chk("R7/R3", "mosi", mosi, xmosi);
         chk("R10", "done", done, xdone);
         chk("R9", "valid", vld, xvld);
         if (xvld && vld) begin
            chk("R4/R9", "addr", addr, kb);
            chk("R4/R9", "data", data, mem_byte(kb));
            nbytes++;
            last_addr = addr;
         end
      end
   end

   task automatic clocks(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic start_load(input logic ph, input logic q);
      @(posedge clk); #1;
      rst_n = 1'b0;
      cpha  = ph;
      quad  = q;
      clocks(3);
      rst_n = 1'b1;
   endtask

   initial begin
      clocks(4);
      chk("R2", "cs_n idle before load", cs_n, 1);
      // R8 single-port image, R7 phase 0
      start_load(1'b0, 1'b0);
      clocks((24 + 8 * LS) * DIV + 20);
      chk("R8", "single byte count", nbytes, LS);
      chk("R8", "single last address", last_addr, 12'h19B);
      chk("R10", "done held", done, 1);
      // R8 quad-port image, R7 phase 1, R2 restart after a second reset
      start_load(1'b1, 1'b1);
      clocks((24 + 8 * LQ) * DIV + 20);
      chk("R8", "quad byte count", nbytes, LQ);
      chk("R8", "quad last address", last_addr, 12'h404);
      // R11 abort mid-image then a fresh load
      start_load(1'b0, 1'b1);
      clocks(3000);
      chk("R11", "transfer active before abort", cs_n, 0);
      start_load(1'b1, 1'b0);
      clocks((24 + 8 * LS) * DIV + 20);
      chk("R11", "restart byte count", nbytes, LS);
      chk("R11", "restart done", done, 1);
      // R1 straps that do not select EEPROM boot
      for (int v = 0; v < 8; v++) begin
         if (v == 2) continue;
         @(posedge clk); #1;
         rst_n = 1'b0;
         {s_hw, s_m1, s_m0} = 3'(v);
         clocks(2);
         rst_n = 1'b1;
         clocks(60);
         chk("R1", "cs_n with straps off", cs_n, 1);
         chk("R1", "done with straps off", done, 0);
         chk("R1", "no bytes with straps off", nbytes, 0);
      end
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule